// File: doc/BRIEF.md
# Completion Count Interrupt Coalescer

This block keeps a running count of finished work items that asked to be reported and decides when software should be interrupted. Software does not want one interrupt per completion. It wants one interrupt when enough results have piled up, or when the oldest pending result has waited long enough. The block fires its interrupt when either of these two conditions is met. Each completion pulse adds one to the count. An acknowledge write subtracts a software-chosen amount from the count. A diagnostic write replaces the count outright.

A hold-off timer runs only while the count is nonzero. It is cleared by every acknowledge or direct write. The interrupt condition is evaluated again on the cycle after such a write, so a count that is still at or above the threshold raises a fresh interrupt at once. The count is visible on an output port, and that port is the value an acknowledge register read would return. The interrupt is a one-cycle request pulse. It is gated by an enable bit that never stops counting or timing.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_cnt_o` is 0 and `irq_o` is 0.
- R2: A cycle with `cmpl_i` high adds one to the count. If the same cycle also has an acknowledge of amount A, the new count is count + 1 - A.
- R3: A cycle with `ack_we_i` high subtracts `ack_amt_i` from the count. The new value appears on `done_cnt_o` after that clock edge.
- R4: A cycle with `cnt_we_i` high loads `cnt_wdata_i` into the count. This write overrides any completion or acknowledge in the same cycle, and it restarts the hold-off timer.
- R5: While the count is zero, the hold-off timer stays at zero and `irq_o` stays low, whatever the time setting.
- R6: The fire condition holds when the count is nonzero and at least `cfg_num_i`. A `cfg_num_i` of 0 is treated as 1.
- R7: The fire condition also holds once the count has stayed nonzero, with no acknowledge or write, for `cfg_time_i`*1024 clock edges. A `cfg_time_i` of 0 turns this time path off.
- R8: An acknowledge or direct write clears the timer and re-arms the edge detector. If the fire condition still holds on the next cycle, a new pulse is issued.
- R9: While `irq_en_i` is 0, `irq_o` stays 0, and counting and timing continue unchanged. Raising the enable while the condition is already high, and already seen, produces no pulse.
- R10: `irq_o` is high for exactly one cycle for each rising edge of the fire condition.
- R11: The timer stops at its limit and does not wrap. A condition held only by the time path therefore gives one pulse, not a repeating one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_i | input | 1 | One completion that requested a done interrupt |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_amt_i | input | CNT_W | Amount subtracted by an acknowledge |
| cnt_we_i | input | 1 | Diagnostic direct write of the count |
| cnt_wdata_i | input | CNT_W | Value loaded by a direct write |
| cfg_num_i | input | CNT_W | Count threshold (0 acts as 1) |
| cfg_time_i | input | TIME_W | Time threshold in units of 1024 cycles (0 = off) |
| irq_en_i | input | 1 | Interrupt enable |
| done_cnt_o | output | CNT_W | Current pending count |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A corrupted count appears on `done_cnt_o` one edge after the event that caused it, and it shifts the cycle of the count-threshold pulse. A timer that is not cleared, or that wraps, shows up as a pulse that comes early, late, or repeats, roughly 1024 cycles after the last acknowledge. A stuck edge detector either drops the re-fire pulse on the cycle after an acknowledge or stretches `irq_o` past one cycle. The bench therefore compares the count and the pulse on every cycle against a cycle model, and it also tallies the pulses in each scenario.

// File: rtl/ccoal_pkg.sv
package ccoal_pkg;

    localparam int unsigned CCOAL_CNT_W      = 20;
    localparam int unsigned CCOAL_TIME_W     = 16;
    localparam int unsigned CCOAL_TICK_SHIFT = 10;

    // Per-cycle update request to the pending counter
    typedef struct packed {
        logic inc;   // one completion
        logic ack;   // subtract acknowledge amount
        logic wr;    // direct overwrite
    } ccoal_ev_t;

    // Any software write to the count re-arms timer and edge detector
    function automatic logic ccoal_restart(input ccoal_ev_t ev);
        return ev.ack | ev.wr;
    endfunction

endpackage

// File: rtl/ccoal_counter.sv
module ccoal_counter
    import ccoal_pkg::*;
#(
    parameter int unsigned CNT_W = CCOAL_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ccoal_ev_t        ev,
    input  logic [CNT_W-1:0] ack_amt,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc_term;
    logic [CNT_W-1:0] sub_term;

    always_comb begin
        inc_term = {{(CNT_W-1){1'b0}}, ev.inc};
        sub_term = ev.ack ? ack_amt : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (ev.wr)  cnt_q <= wr_val;
        else             cnt_q <= cnt_q + inc_term - sub_term;
    end

    assign cnt_o = cnt_q;

    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        (ev.inc && !ev.ack && !ev.wr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_CNT_WR: assert property (@(posedge clk) disable iff (rst)
        ev.wr |=> (cnt_q == $past(wr_val))); // R4

endmodule

// File: rtl/ccoal_timer.sv
module ccoal_timer #(
    parameter int unsigned TIME_W     = 16,
    parameter int unsigned TICK_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pending,
    input  logic              restart,
    input  logic [TIME_W-1:0] cfg_time,
    output logic              expired_o
);

    localparam int unsigned TMR_W = TIME_W + TICK_SHIFT;

    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] limit;
    logic             at_limit;

    generate
        if (TICK_SHIFT == 0) begin : g_no_scale
            assign limit = cfg_time;
        end else begin : g_scale
            assign limit = {cfg_time, {TICK_SHIFT{1'b0}}};
        end
    endgenerate

    assign at_limit = (tmr_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !pending || restart) tmr_q <= '0;
        else if (!at_limit)             tmr_q <= tmr_q + TMR_W'(1);
    end

    assign expired_o = (cfg_time != '0) && at_limit;

    AST_TMR_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pending |=> (tmr_q == '0)); // R5

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (at_limit && pending && !restart) |=> (tmr_q == $past(tmr_q))); // R11

endmodule

// File: rtl/ccoal_fire.sv
module ccoal_fire #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cfg_num,
    input  logic             expired,
    input  logic             restart,
    input  logic             irq_en,
    output logic             irq_o
);

    logic [CNT_W-1:0] eff_num;
    logic             fire;
    logic             prev_q;

    always_comb begin
        eff_num = (cfg_num == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cfg_num;
        fire    = (cnt != '0) && ((cnt >= eff_num) || expired);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) prev_q <= 1'b0;
        else                prev_q <= fire;
    end

    assign irq_o = irq_en & fire & ~prev_q;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_o); // R9

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !restart) |=> !irq_o); // R10

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !irq_o); // R5

endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
    import ccoal_pkg::*;
#(
    parameter int unsigned CNT_W      = CCOAL_CNT_W,
    parameter int unsigned TIME_W     = CCOAL_TIME_W,
    parameter int unsigned TICK_SHIFT = CCOAL_TICK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmpl_i,
    input  logic              ack_we_i,
    input  logic [CNT_W-1:0]  ack_amt_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic [CNT_W-1:0]  cfg_num_i,
    input  logic [TIME_W-1:0] cfg_time_i,
    input  logic              irq_en_i,
    output logic [CNT_W-1:0]  done_cnt_o,
    output logic              irq_o
);

    ccoal_ev_t        ev;
    logic             restart;
    logic             pending;
    logic             expired;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        ev.inc  = cmpl_i;
        ev.ack  = ack_we_i;
        ev.wr   = cnt_we_i;
        restart = ccoal_restart(ev);
    end

    ccoal_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ack_amt (ack_amt_i),
        .wr_val  (cnt_wdata_i),
        .cnt_o   (cnt)
    );

    assign pending = (cnt != '0);

    ccoal_timer #(.TIME_W(TIME_W), .TICK_SHIFT(TICK_SHIFT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .restart   (restart),
        .cfg_time  (cfg_time_i),
        .expired_o (expired)
    );

    ccoal_fire #(.CNT_W(CNT_W)) u_fire (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cfg_num (cfg_num_i),
        .expired (expired),
        .restart (restart),
        .irq_en  (irq_en_i),
        .irq_o   (irq_o)
    );

    assign done_cnt_o = cnt;

    AST_ACK_UPDATES_CNT: assert property (@(posedge clk) disable iff (rst)
        (ack_we_i && !cnt_we_i && !cmpl_i) |=> (done_cnt_o == $past(done_cnt_o) - $past(ack_amt_i))); // R3

    AST_WR_BEATS_EVENTS: assert property (@(posedge clk) disable iff (rst)
        (cnt_we_i && (cmpl_i || ack_we_i)) |=> (done_cnt_o == $past(cnt_wdata_i))); // R4

endmodule

// File: tb/test_cmpl_irq_coalescer.sv
module test_cmpl_irq_coalescer;

    localparam int CW = 20;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmpl_i = 1'b0;
    logic          ack_we_i = 1'b0;
    logic [CW-1:0] ack_amt_i = '0;
    logic          cnt_we_i = 1'b0;
    logic [CW-1:0] cnt_wdata_i = '0;
    logic [CW-1:0] cfg_num_i = '0;
    logic [TW-1:0] cfg_time_i = '0;
    logic          irq_en_i = 1'b0;
    logic [CW-1:0] done_cnt_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 0;
    string cur_tag = "R1";

    typedef struct {
        logic [CW-1:0] cnt;
        int            tmr;
        logic          prev;
    } exp_t;

    exp_t sb_q[$];

    logic [CW-1:0] m_cnt = '0;
    int            m_tmr = 0;
    logic          m_prev = 1'b0;

    cmpl_irq_coalescer i_cmpl_irq_coalescer (
        .clk         (clk),
        .rst         (rst),
        .cmpl_i      (cmpl_i),
        .ack_we_i    (ack_we_i),
        .ack_amt_i   (ack_amt_i),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .cfg_num_i   (cfg_num_i),
        .cfg_time_i  (cfg_time_i),
        .irq_en_i    (irq_en_i),
        .done_cnt_o  (done_cnt_o),
        .irq_o       (irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic model_fire(input logic [CW-1:0] c, input int t);
        int lim;
        logic [CW-1:0] n;
        lim = int'(cfg_time_i) * 1024;
        n   = (cfg_num_i == 0) ? CW'(1) : cfg_num_i;
        return (c != 0) && ((c >= n) || ((cfg_time_i != 0) && (t >= lim)));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances on each edge, pushes expected post-edge state
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = '0;
            m_tmr  = 0;
            m_prev = 1'b0;
        end else begin
            logic rs;
            logic f_old;
            int   lim;
            exp_t it;
            rs    = ack_we_i | cnt_we_i;
            f_old = model_fire(m_cnt, m_tmr);
            lim   = int'(cfg_time_i) * 1024;
            if (m_cnt == 0 || rs) m_tmr = 0;
            else if (m_tmr < lim) m_tmr = m_tmr + 1;
            if (cnt_we_i) m_cnt = cnt_wdata_i;
            else m_cnt = m_cnt + CW'(cmpl_i) - (ack_we_i ? ack_amt_i : CW'(0));
            m_prev = rs ? 1'b0 : f_old;
            it.cnt = m_cnt; it.tmr = m_tmr; it.prev = m_prev;
            sb_q.push_back(it);
        end
    end

    // Monitor: pops one expected item per cycle and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (irq_o === 1'b1) pulses++;
            if (sb_q.size() > 0) begin
                exp_t it;
                logic ex_irq;
                it = sb_q.pop_front();
                ex_irq = irq_en_i & model_fire(it.cnt, it.tmr) & ~it.prev;
                check({cur_tag, " count"}, int'(done_cnt_o), int'(it.cnt));
                check({cur_tag, " irq"}, int'(irq_o), int'(ex_irq));
            end
        end
    end

    task automatic drive(input logic c, input logic aw, input int amt,
                         input logic ww, input int wd);
        @(negedge clk);
        cmpl_i = c; ack_we_i = aw; ack_amt_i = CW'(amt);
        cnt_we_i = ww; cnt_wdata_i = CW'(wd);
        @(negedge clk);
        cmpl_i = 1'b0; ack_we_i = 1'b0; ack_amt_i = '0;
        cnt_we_i = 1'b0; cnt_wdata_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_pulses(output int p);
        idle(3);
        #6;
        p = pulses;
    endtask

    initial begin
        int p0;
        int p1;
        cfg_num_i = CW'(3); cfg_time_i = '0; irq_en_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        check("R1 reset count", int'(done_cnt_o), 0);
        check("R1 reset irq", int'(irq_o), 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R6: count threshold
        cur_tag = "R6";
        settle_pulses(p0);
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        settle_pulses(p1);
        check("R6 one pulse at threshold", p1 - p0, 1);
        check("R2 count after three completions", int'(done_cnt_o), 3);

        // R3 and R8: acknowledge and re-fire
        cur_tag = "R3";
        drive(0, 1, 1, 0, 0);
        settle_pulses(p0);
        check("R3 count after ack", int'(done_cnt_o), 2);
        cur_tag = "R8";
        drive(1, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0);
        settle_pulses(p1);
        check("R8 pulse on reach and on re-fire", p1 - p0, 2);

        // R2: simultaneous completion and acknowledge
        cur_tag = "R2";
        drive(1, 1, 2, 0, 0);
        settle_pulses(p0);
        check("R2 count+1-ack", int'(done_cnt_o), 2);

        // R4: direct write
        cur_tag = "R4";
        drive(1, 1, 1, 1, 5);
        settle_pulses(p1);
        check("R4 write overrides", int'(done_cnt_o), 5);
        check("R4 write fires", p1 - p0, 1);
        drive(0, 0, 0, 1, 0);

        // R6: zero threshold acts as one
        cur_tag = "R6";
        cfg_num_i = '0;
        settle_pulses(p0);
        drive(1, 0, 0, 0, 0);
        settle_pulses(p1);
        check("R6 num zero as one", p1 - p0, 1);
        drive(0, 0, 0, 1, 0);

        // R9: enable off
        cur_tag = "R9";
        cfg_num_i = CW'(3);
        irq_en_i = 1'b0;
        settle_pulses(p0);
        repeat (4) drive(1, 0, 0, 0, 0);
        settle_pulses(p1);
        check("R9 no pulse while disabled", p1 - p0, 0);
        check("R9 counting continues", int'(done_cnt_o), 4);
        @(negedge clk); irq_en_i = 1'b1;
        settle_pulses(p0);
        check("R9 enable alone no pulse", p0 - p1, 0);
        drive(0, 1, 0, 0, 0);
        settle_pulses(p1);
        check("R9 pulse after ack once enabled", p1 - p0, 1);
        drive(0, 0, 0, 1, 0);

        // R7 and R11: time path and saturation
        cur_tag = "R7";
        cfg_num_i = CW'(100); cfg_time_i = TW'(1);
        settle_pulses(p0);
        drive(1, 0, 0, 0, 0);
        idle(1000);
        settle_pulses(p1);
        check("R7 no pulse before 1024", p1 - p0, 0);
        idle(100);
        settle_pulses(p1);
        check("R7 time pulse", p1 - p0, 1);
        cur_tag = "R11";
        idle(600);
        settle_pulses(p0);
        check("R11 no repeat after saturation", p0 - p1, 0);
        cur_tag = "R8";
        drive(0, 1, 0, 0, 0);
        idle(500);
        settle_pulses(p1);
        check("R8 ack restarts timer", p1 - p0, 0);
        idle(600);
        settle_pulses(p1);
        check("R8 time pulse after restart", p1 - p0, 1);
        drive(0, 0, 0, 1, 0);

        // R5: nothing pending
        cur_tag = "R5";
        settle_pulses(p0);
        idle(1500);
        settle_pulses(p1);
        check("R5 no pulse with zero count", p1 - p0, 0);

        // R7: time zero disables the time path
        cur_tag = "R7";
        cfg_time_i = '0;
        drive(1, 0, 0, 0, 0);
        idle(1500);
        settle_pulses(p0);
        check("R7 time zero disables", p0 - p1, 0);
        drive(0, 0, 0, 1, 0);
        idle(3);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule